// File: doc/BRIEF.md
# Halfword Settings Bus Slave

This block is a write-only configuration slave on a 16-bit memory-mapped bus. Downstream logic expects 32-bit settings writes, each a one-cycle strobe that carries a slot index and a data word. The bus carries only 16 bits per write, so software sends each 32-bit setting as two halfword writes. The block keeps the first half until the second half arrives and then sends the whole word downstream.

The slave answers to a window of `NUM_SLOTS` slots, each 4 bytes wide. The window starts at `SLAVE_ID << SLAVE_SHIFT`, which is byte address 0x400 with the default values. A write to the halfword at byte offset 0 of a slot (address bit 1 clear) holds the low 16 bits. A write to the halfword at byte offset 2 (address bit 1 set) supplies the high 16 bits and completes the word. The block keeps one held low half at a time. There is no read path: reads return zero and change nothing.

Top module: `halfword_settings_bus`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `set_stb` is 0 and `set_idx` and `set_data` are 0. Reset also drops any held low half.
- R2: A low-half write (address bit 1 = 0) stores `bus_wdata` as the held low half for that slot and produces no strobe.
- R3: A high-half write (address bit 1 = 1) to the slot whose low half is held raises `set_stb` in the next cycle only, with `set_data` = {high write data, held low half}. The held half is then consumed.
- R4: `set_stb` is never high in two consecutive cycles.
- R5: A high-half write to a slot with no held low half is ignored: no strobe, and any low half held for another slot stays held.
- R6: A low-half write to any slot replaces the held low half and its slot. Only a high-half write to the newest slot completes the word.
- R7: Once a word has been strobed, another high-half write to the same slot produces no strobe until a new low half is written.
- R8: Reads (`bus_cs`=1, `bus_we`=0) return `bus_rdata` = 0, produce no strobe and leave the held half unchanged.
- R9: A write is ignored if its address is outside [base, base + 4*NUM_SLOTS) or has bit 0 set. This holds even when the low address bits match a slot.
- R10: `set_idx` and `set_data` keep their values in every cycle where `set_stb` is 0.
- R11: The slot index is (address − base) / 4, with base = SLAVE_ID << SLAVE_SHIFT (0x400 by default). Slots 0 and NUM_SLOTS−1 are both reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | HALF_W | Write halfword |
| bus_rdata | output | HALF_W | Read data, always zero |
| set_stb | output | 1 | One-cycle settings write strobe |
| set_idx | output | SLOT_W | Slot index of the strobed word |
| set_data | output | 2*HALF_W | Assembled settings word |

## Verification
The assertions assume that `bus_cs`, `bus_we`, `bus_addr` and `bus_wdata` are stable and defined across each rising edge. They also assume that a write lasts exactly one cycle. The bench changes the bus only on falling edges and sends each access as a single-cycle pulse followed by an idle cycle. Addresses are chosen both inside and outside the window. Some outside addresses alias a slot in their low bits, and some have bit 0 set, so the decode is tested at its limits without breaking those input rules.

// File: rtl/halfword_settings_pkg.sv
package halfword_settings_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2
  } acc_kind_e;

  function automatic int window_base(input int slave_id, input int slave_shift);
    return slave_id << slave_shift;
  endfunction

endpackage

// File: rtl/hsb_decode.sv
module hsb_decode
  import halfword_settings_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SLOT_W      = 6,
  parameter int SLAVE_ID    = 8,
  parameter int SLAVE_SHIFT = 7
) (
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output acc_kind_e         kind,
  output logic [SLOT_W-1:0] slot
);
  localparam int OFF_W    = SLOT_W + 2;
  localparam int BASE_INT = window_base(SLAVE_ID, SLAVE_SHIFT);
  localparam int WIN_INT  = 4 << SLOT_W;
  localparam logic [ADDR_W-1:0] BASE = BASE_INT[ADDR_W-1:0];
  localparam bit ALIGNED  = (BASE_INT % WIN_INT) == 0;

  logic hit;

  // slot number relative to the window base
  assign slot = bus_addr[OFF_W-1:2] - BASE[OFF_W-1:2];

  generate
    if (ALIGNED) begin : g_aligned
      assign hit = (bus_addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]) && !bus_addr[0];
    end else begin : g_range
      localparam logic [ADDR_W:0] LIMIT = ADDR_W'(BASE_INT) + (ADDR_W+1)'(WIN_INT);
      assign hit = (bus_addr >= BASE) && ({1'b0, bus_addr} < LIMIT) && !bus_addr[0];
    end
  endgenerate

  always_comb begin
    kind = ACC_NONE;
    if (bus_cs && bus_we && hit) begin
      kind = bus_addr[1] ? ACC_HI : ACC_LO;
    end
  end
endmodule

// File: rtl/hsb_stage.sv
module hsb_stage
  import halfword_settings_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  acc_kind_e             kind,
  input  logic [SLOT_W-1:0]     slot,
  input  logic [HALF_W-1:0]     wdata,
  output logic                  fire,
  output logic [SLOT_W-1:0]     fire_slot,
  output logic [2*HALF_W-1:0]   fire_word
);
  logic              held_v;
  logic [SLOT_W-1:0] held_slot;
  logic [HALF_W-1:0] held_lo;

  assign fire      = (kind == ACC_HI) && held_v && (held_slot == slot);
  assign fire_slot = slot;
  assign fire_word = {wdata, held_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      held_v    <= 1'b0;
      held_slot <= '0;
      held_lo   <= '0;
    end else if (kind == ACC_LO) begin
      held_v    <= 1'b1;
      held_slot <= slot;
      held_lo   <= wdata;
    end else if (fire) begin
      held_v    <= 1'b0;
    end
  end
endmodule

// File: rtl/hsb_emit.sv
module hsb_emit #(
  parameter int SLOT_W = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [SLOT_W-1:0] fire_slot,
  input  logic [WORD_W-1:0] fire_word,
  output logic              set_stb,
  output logic [SLOT_W-1:0] set_idx,
  output logic [WORD_W-1:0] set_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      set_stb  <= 1'b0;
      set_idx  <= '0;
      set_data <= '0;
    end else begin
      set_stb <= fire;
      if (fire) begin
        set_idx  <= fire_slot;
        set_data <= fire_word;
      end
    end
  end
endmodule

// File: rtl/halfword_settings_bus.sv
module halfword_settings_bus
  import halfword_settings_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int HALF_W      = 16,
  parameter int NUM_SLOTS   = 64,
  parameter int SLAVE_ID    = 8,
  parameter int SLAVE_SHIFT = 7,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int WORD_W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              set_stb,
  output logic [SLOT_W-1:0] set_idx,
  output logic [WORD_W-1:0] set_data
);
  acc_kind_e         kind;
  logic [SLOT_W-1:0] slot;
  logic              fire;
  logic [SLOT_W-1:0] fire_slot;
  logic [WORD_W-1:0] fire_word;

  assign bus_rdata = '0;

  hsb_decode #(
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .SLAVE_ID(SLAVE_ID), .SLAVE_SHIFT(SLAVE_SHIFT)
  ) u_decode (
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr), .kind(kind), .slot(slot)
  );

  hsb_stage #(.SLOT_W(SLOT_W), .HALF_W(HALF_W)) u_stage (
    .clk(clk), .rst(rst), .kind(kind), .slot(slot), .wdata(bus_wdata),
    .fire(fire), .fire_slot(fire_slot), .fire_word(fire_word)
  );

  hsb_emit #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_emit (
    .clk(clk), .rst(rst), .fire(fire), .fire_slot(fire_slot), .fire_word(fire_word),
    .set_stb(set_stb), .set_idx(set_idx), .set_data(set_data)
  );
endmodule

// File: rtl/halfword_settings_bus_chk.sv
module halfword_settings_bus_chk #(
  parameter int ADDR_W      = 16,
  parameter int HALF_W      = 16,
  parameter int NUM_SLOTS   = 64,
  parameter int SLAVE_ID    = 8,
  parameter int SLAVE_SHIFT = 7,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int WORD_W     = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cs,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [HALF_W-1:0] bus_wdata,
  input logic              set_stb,
  input logic [SLOT_W-1:0] set_idx,
  input logic [WORD_W-1:0] set_data
);
  localparam int BASE = SLAVE_ID << SLAVE_SHIFT;
  localparam int WIN  = 4 * NUM_SLOTS;

  logic              in_win;
  logic [SLOT_W-1:0] addr_slot;
  assign in_win    = (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + WIN) && !bus_addr[0];
  assign addr_slot = SLOT_W'((int'(bus_addr) - BASE) >> 2);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> !set_stb);

  p_low_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_cs && bus_we && in_win && !bus_addr[1]) |=> !set_stb);

  p_stb_cause_r3: assert property (@(posedge clk) disable iff (rst)
    set_stb |-> $past(bus_cs && bus_we && in_win && bus_addr[1]));

  p_upper_data_r3: assert property (@(posedge clk) disable iff (rst)
    set_stb |-> set_data[WORD_W-1:HALF_W] == $past(bus_wdata));

  p_slot_index_r11: assert property (@(posedge clk) disable iff (rst)
    set_stb |-> set_idx == $past(addr_slot));

  p_read_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_cs && !bus_we) |=> !set_stb);

  p_outside_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_cs && bus_we && !in_win) |=> !set_stb);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !set_stb |-> ($stable(set_idx) && $stable(set_data)));
endmodule

bind halfword_settings_bus halfword_settings_bus_chk #(
  .ADDR_W(ADDR_W), .HALF_W(HALF_W), .NUM_SLOTS(NUM_SLOTS),
  .SLAVE_ID(SLAVE_ID), .SLAVE_SHIFT(SLAVE_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .set_stb(set_stb), .set_idx(set_idx), .set_data(set_data)
);

// File: tb/halfword_settings_bus_tb.sv
module halfword_settings_bus_tb;
  localparam int BASE = 'h400;
  localparam int WIN  = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        set_stb;
  logic [5:0]  set_idx;
  logic [31:0] set_data;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";

  // reference model state
  bit          m_held_v = 0;
  int          m_held_slot = 0;
  logic [15:0] m_held_lo = '0;
  bit          e_stb = 0;
  int          e_idx = 0;
  logic [31:0] e_data = '0;

  always #2 clk = ~clk;

  halfword_settings_bus u_dut (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_stb(set_stb),
    .set_idx(set_idx), .set_data(set_data)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_held_v = 0; e_stb = 0; e_idx = 0; e_data = '0;
    end else begin
      int a;
      a = int'(bus_addr);
      e_stb = 0;
      if (bus_cs && bus_we && a >= BASE && a < BASE + WIN && a % 2 == 0) begin
        int s;
        s = (a - BASE) / 4;
        if ((a % 4) == 0) begin
          m_held_v = 1; m_held_slot = s; m_held_lo = bus_wdata;
        end else if (m_held_v && m_held_slot == s) begin
          e_stb = 1; e_idx = s; e_data = {bus_wdata, m_held_lo}; m_held_v = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (set_stb !== e_stb || int'(set_idx) != e_idx || set_data !== e_data) begin
      errors++;
      $display("FAIL %s: stb/idx/data got %0b/%0d/%h exp %0b/%0d/%h",
               phase, set_stb, set_idx, set_data, e_stb, e_idx, e_data);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [15:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = 1; bus_addr = 16'(addr); bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
    idle(1);
  endtask

  task automatic rd(input int addr);
    @(negedge clk);
    bus_cs = 1; bus_we = 0; bus_addr = 16'(addr);
    #1;
    checks++;
    if (bus_rdata !== 16'h0) begin
      errors++;
      $display("FAIL R8: rdata got %h exp 0000", bus_rdata);
    end
    @(negedge clk);
    bus_cs = 0;
    idle(1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    phase = "R1";
    idle(4);
    rst = 0;
    idle(2);
    phase = "R3";
    wr(BASE + 5*4, 16'h1234);
    wr(BASE + 5*4 + 2, 16'hABCD);
    phase = "R11";
    wr(BASE + 0, 16'h0001);
    wr(BASE + 2, 16'h8000);
    wr(BASE + 63*4, 16'hFFFF);
    wr(BASE + 63*4 + 2, 16'h5A5A);
    phase = "R2";
    wr(BASE + 9*4, 16'hC0DE);
    idle(3);
    phase = "R5";
    wr(BASE + 7*4 + 2, 16'hDEAD);
    wr(BASE + 9*4 + 2, 16'hBEEF);
    phase = "R7";
    wr(BASE + 9*4 + 2, 16'h7777);
    wr(BASE + 9*4 + 2, 16'h6666);
    phase = "R6";
    wr(BASE + 10*4, 16'h1111);
    wr(BASE + 11*4, 16'h2222);
    wr(BASE + 10*4 + 2, 16'h3333);
    wr(BASE + 11*4 + 2, 16'h4444);
    phase = "R8";
    wr(BASE + 4*4, 16'h9999);
    rd(BASE + 4*4);
    rd(BASE + 4*4 + 2);
    rd(BASE + 20);
    wr(BASE + 4*4 + 2, 16'h8888);
    phase = "R9";
    wr(BASE + 2*4, 16'h0F0F);
    wr(BASE + WIN + 2*4 + 2, 16'hAAAA);
    wr(BASE - 4 + 2, 16'hBBBB);
    wr(BASE + WIN + 2*4, 16'hCCCC);
    wr(BASE + 2*4 + 1, 16'hDDDD);
    wr(BASE + 2*4 + 3, 16'hEEEE);
    wr(BASE + 2*4 + 2, 16'hF0F0);
    phase = "R10";
    idle(4);
    phase = "R1";
    wr(BASE + 12*4, 16'h1357);
    @(negedge clk); rst = 1;
    idle(2);
    rst = 0;
    wr(BASE + 12*4 + 2, 16'h2468);
    idle(2);
    finish_run();
  end
endmodule